// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block watches a bank of external pins and raises flags when a pin shows a chosen condition. Each pin has a small trigger code that selects one of several conditions, or none. The conditions are a rising transition, a falling transition, any transition, a held low level and a held high level. Pins are first brought into the clock domain through a synchronizer. Transitions are then found by comparing each synchronized sample with the one taken on the previous clock.

Software reaches the block through a simple register window. There is one control word per pin, and the trigger code sits in a four-bit field of that word. A single shared status word holds one sticky flag per pin. Writing a 1 to a flag bit clears it. A single interrupt line is the OR of every flag, so one handler can service the whole bank. It reads the status word, then writes the set bits back to clear them. In level modes a flag keeps coming back for as long as the level lasts, so the condition must be removed before a clear will stick.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset every trigger code reads 0, every status flag is 0 and `irq_out` is 0.
- R2: The control word of pin n sits at byte address 4*n. Its trigger code occupies bits 19:16, and every other bit reads back 0. The status word is at address 0xA0, with bit n belonging to pin n. Any other address, including a misaligned one, reads 0.
- R3: Code 0x9 (rising) sets the flag of a pin on a 0-to-1 change of the pin. The flag is first visible after the third rising clock edge that follows the change, because the input passes two synchronizer stages and then the flag register.
- R4: Code 0xA (falling) sets the flag on a 1-to-0 change of the pin.
- R5: Code 0xB (either) sets the flag on any change of the pin.
- R6: Code 0x8 (low level) sets the flag on every clock while the synchronized pin is 0. A clear issued during that time does not remove it.
- R7: Code 0xC (high level) sets the flag on every clock while the synchronized pin is 1. A clear issued during that time does not remove it.
- R8: Code 0x0 and every code not named in R3 to R7 set no flag, whatever the pin does.
- R9: Writing the status word clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A flag holds once set, even after its condition goes away.
- R10: When a new event and a clear hit the same flag in the same clock, the flag ends up set.
- R11: `irq_out` is 1 exactly when at least one status flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from `reg_addr` |
| irq_out | output | 1 | Combined interrupt, OR of all flags |

## Verification
Some rules are checked by the assertions on every clock:
- a held level, low or high, puts its flag in the status register on the next clock;
- an unlisted code never raises a quiet flag;
- a clear empties the flags it names unless a set competes for them;
- flags only go away through a clear;
- a rising or falling hit lasts a single clock.

Other behaviour can only be shown by the bench's scenarios. These are the exact three-edge latency, the readback masking of the control word, and the way a level clear is overridden. They also include the full sweep of all sixteen codes against rise, fall and steady patterns on pins at both ends of the bank.

// File: rtl/pid_pkg.sv
// Package: shared trigger codes and register field placement for the
// per-pin interrupt detector. Assumes a four-bit trigger field.
package pid_pkg;
    localparam int CFG_W   = 4;
    localparam int CFG_LSB = 16;

    typedef enum logic [CFG_W-1:0] {
        TRIG_OFF  = 4'h0,
        TRIG_LOW  = 4'h8,
        TRIG_RISE = 4'h9,
        TRIG_FALL = 4'hA,
        TRIG_BOTH = 4'hB,
        TRIG_HIGH = 4'hC
    } trig_code_e;

    // True for a code that selects a detection condition
    function automatic logic code_active(input logic [CFG_W-1:0] c);
        return (c == TRIG_LOW)  || (c == TRIG_RISE) || (c == TRIG_FALL) ||
               (c == TRIG_BOTH) || (c == TRIG_HIGH);
    endfunction
endpackage

// File: rtl/pid_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Assumes STAGES >= 1 and that each bit may be resampled independently.
module pid_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift pin samples through the synchronizer stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= '0;
        end else begin
            chain[0] <= d_async;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pid_pin_cell.sv
// Module: one pin's trigger code register and condition detector.
// Assumes pin_s is already synchronized. The hit output is combinational
// from the code, the current sample and the previous sample.
module pid_pin_cell
    import pid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             pin_s,
    output logic [CFG_W-1:0] cfg_q,
    output logic             hit
);
    logic prev_s;

    // Hold the trigger code written by software
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= TRIG_OFF;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end

    // Remember the previous synchronized sample for transition detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_s <= 1'b0;
        else        prev_s <= pin_s;
    end

    // Decode the trigger code into a per-clock hit
    always_comb begin
        case (cfg_q)
            TRIG_LOW:  hit = ~pin_s;
            TRIG_RISE: hit = pin_s & ~prev_s;
            TRIG_FALL: hit = ~pin_s & prev_s;
            TRIG_BOTH: hit = pin_s ^ prev_s;
            TRIG_HIGH: hit = pin_s;
            default:   hit = 1'b0;
        endcase
    end

    // R3/R4: a single-direction transition hit lasts one clock
    a_r3_edge_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (cfg_q == TRIG_RISE || cfg_q == TRIG_FALL))
        |=> !(hit && cfg_q == $past(cfg_q)));
endmodule

// File: rtl/pid_status.sv
// Module: sticky status flags with write-1-to-clear, where a set wins.
// Assumes set_vec and clr_vec are valid on each clock and one-cycle wide.
module pid_status #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);
    // Update flags: clear the named bits, then merge new events
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_vec) | set_vec;
    end

    // R1: flags are empty on the first clock after reset
    a_r1_flags_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> flags == '0);

    // R9: an uncontested clear empties the named flags
    a_r9_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        |(clr_vec & ~set_vec) |=> (flags & $past(clr_vec & ~set_vec)) == '0);

    // R9: a flag that is not cleared stays set
    a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        |(flags & ~clr_vec) |=> ($past(flags & ~clr_vec) & ~flags) == '0);

    // R10: a new event always lands, even against a clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        |set_vec |=> (flags & $past(set_vec)) == $past(set_vec));
endmodule

// File: rtl/pin_irq_detect.sv
// Module: top of the per-pin interrupt detector. It decodes the register
// window and combines the pin cells into the shared status word and one
// interrupt line. Assumes DATA_W >= NUM_PINS, DATA_W >= 20, and that
// 4*NUM_PINS and STATUS_ADDR fit in ADDR_W bits.
module pin_irq_detect
    import pid_pkg::*;
#(
    parameter int              NUM_PINS    = 32,
    parameter int              ADDR_W      = 8,
    parameter int              DATA_W      = 32,
    parameter int              SYNC_STAGES = 2,
    parameter logic [7:0]      STATUS_ADDR = 8'hA0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq_out
);
    localparam int IDX_W    = $clog2(NUM_PINS);
    localparam int WORD_W   = ADDR_W - 2;
    localparam int CTRL_END = 4 * NUM_PINS;

    logic [NUM_PINS-1:0] pin_s;
    logic [NUM_PINS-1:0] hit_vec;
    logic [NUM_PINS-1:0] clr_vec;
    logic [NUM_PINS-1:0] status;
    logic [CFG_W-1:0]    cfg_arr [NUM_PINS];
    logic [WORD_W-1:0]   word_idx;
    logic                ctrl_space;
    logic                status_sel;

    assign word_idx   = reg_addr[ADDR_W-1:2];
    assign ctrl_space = (reg_addr[1:0] == 2'b00) &&
                        ({1'b0, reg_addr} < (ADDR_W+1)'(CTRL_END));
    assign status_sel = (reg_addr == ADDR_W'(STATUS_ADDR));

    pid_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_s)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_PINS; i++) begin : g_pin
            logic cell_we;
            assign cell_we = reg_wr && ctrl_space && (word_idx == WORD_W'(i));

            pid_pin_cell cell_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .cfg_we    (cell_we),
                .cfg_wdata (reg_wdata[CFG_LSB +: CFG_W]),
                .pin_s     (pin_s[i]),
                .cfg_q     (cfg_arr[i]),
                .hit       (hit_vec[i])
            );

            // R6: a held low level lands in the status register
            a_r6_low_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_arr[i] == TRIG_LOW && !pin_s[i]) |=> status[i]);

            // R7: a held high level lands in the status register
            a_r7_high_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_arr[i] == TRIG_HIGH && pin_s[i]) |=> status[i]);

            // R8: an inactive code never raises a quiet flag
            a_r8_inactive_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                (!code_active(cfg_arr[i]) && !status[i]) |=> !status[i]);
        end
    endgenerate

    // Route status-word writes to the write-1-to-clear vector
    always_comb begin
        clr_vec = '0;
        if (reg_wr && status_sel) clr_vec = reg_wdata[NUM_PINS-1:0];
    end

    pid_status #(.N(NUM_PINS)) status_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (hit_vec),
        .clr_vec (clr_vec),
        .flags   (status)
    );

    // Select read data for the addressed register
    always_comb begin
        reg_rdata = '0;
        if (status_sel)
            reg_rdata[NUM_PINS-1:0] = status;
        else if (ctrl_space)
            reg_rdata[CFG_LSB +: CFG_W] = cfg_arr[word_idx[IDX_W-1:0]];
    end

    assign irq_out = |status;
endmodule

// File: tb/pin_irq_detect_tb_top.sv
`timescale 1ns/1ps
module pin_irq_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pin_irq_detect dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_status(input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(8'hA0, v);
        check(v, exp, tag);
        check({31'b0, irq_out}, {31'b0, exp != 0}, {tag, " R11 irq"});
    endtask

    function automatic logic on_rise(input int c);
        return c == 9 || c == 11 || c == 12 || c == 8;
    endfunction

    function automatic logic on_fall(input int c);
        return c == 10 || c == 11 || c == 12 || c == 8;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int pins [3] = '{0, 5, 31};
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_status(32'h0, "R1 status");
        for (int n = 0; n < 32; n++) begin
            rd(8'(4*n), v);
            check(v, 32'h0, "R1 ctrl");
        end

        // R2: readback masking and unmapped addresses
        wr(8'd0, 32'hFFF9_FFFF);
        rd(8'd0, v);   check(v, 32'h0009_0000, "R2 ctrl mask");
        rd(8'h02, v);  check(v, 32'h0, "R2 misaligned");
        rd(8'h80, v);  check(v, 32'h0, "R2 unmapped");
        wr(8'd0, 32'h0);

        // R3: three-edge latency for a rising transition
        wr(8'd12, 32'h0009_0000);
        wr(8'hA0, 32'hFFFF_FFFF);
        pin_in[3] = 1'b1;
        wait_n(2); check_status(32'h0, "R3 not yet");
        wait_n(1); check_status(32'h8, "R3 latency");
        pin_in[3] = 1'b0;
        wait_n(4); check_status(32'h8, "R9 sticky");
        wr(8'd12, 32'h0);
        wr(8'hA0, 32'h8);
        check_status(32'h0, "R9 cleared");

        // R9: partial clear with two flags set
        wr(8'd0, 32'h0009_0000);
        wr(8'd124, 32'h0009_0000);
        pin_in[0] = 1'b1; pin_in[31] = 1'b1;
        wait_n(4); check_status(32'h8000_0001, "R3 two pins");
        wr(8'hA0, 32'h1);          check_status(32'h8000_0000, "R9 bit0 only");
        wr(8'hA0, 32'h0);          check_status(32'h8000_0000, "R9 zero write");
        wr(8'hA0, 32'h8000_0000);  check_status(32'h0, "R9 bit31");
        wr(8'd0, 32'h0); wr(8'd124, 32'h0);
        pin_in[0] = 1'b0; pin_in[31] = 1'b0;
        wait_n(4);
        check_status(32'h0, "R8 masked no flag");

        // R10: clear lands in the same clock as a rising event
        wr(8'd8, 32'h0009_0000);
        pin_in[2] = 1'b1;
        wait_n(2);
        wr(8'hA0, 32'h4);
        check_status(32'h4, "R10 set wins");
        wr(8'hA0, 32'h4);
        check_status(32'h0, "R10 then clear");
        wr(8'd8, 32'h0);
        pin_in[2] = 1'b0;
        wait_n(4);

        // Sweep of every code on pins at both ends and the middle
        foreach (pins[k]) begin
            int p = pins[k];
            for (int c = 0; c < 16; c++) begin
                logic [31:0] bitp = 32'h1 << p;
                wr(8'(4*p), {12'hABC, 4'(c), 16'h1234});
                rd(8'(4*p), v);
                check(v, 32'(c) << 16, "R2 code readback");
                wait_n(4);
                wr(8'hA0, 32'hFFFF_FFFF);
                check_status((c == 8) ? bitp : 32'h0, "R6 R8 steady low");
                pin_in[p] = 1'b1;
                wait_n(4);
                check_status(on_rise(c) ? bitp : 32'h0, "R3 R5 R7 R8 rise");
                wr(8'hA0, 32'hFFFF_FFFF);
                check_status((c == 12) ? bitp : 32'h0, "R7 R8 steady high");
                wr(8'hA0, 32'hFFFF_FFFF);
                pin_in[p] = 1'b0;
                wait_n(4);
                check_status(on_fall(c) ? bitp : 32'h0, "R4 R5 R6 R8 fall");
                wr(8'hA0, 32'hFFFF_FFFF);
                check_status((c == 8) ? bitp : 32'h0, "R6 R8 low again");
                wr(8'(4*p), 32'h0);
                wr(8'hA0, 32'hFFFF_FFFF);
                check_status(32'h0, "R9 R11 idle");
            end
        end

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule